// File: doc/BRIEF.md
# Concatenation Map Mismatch Checker

This block checks the concatenation layout of a 48-slot STS-1 path against the layout software expects. The path is split into four STS-12 bytestreams, A to D, with twelve time slots each. Software programs two things for every slot: an expected state (concatenated or normal) and a compare-enable bit. The incoming map arrives as a 48-bit vector with a one-cycle valid strobe. On each strobe the block latches the vector, so software can read back the received state. It also compares each enabled slot against its expected value.

Mismatches are not reported per slot. Each one is folded into a sticky alarm bit for its bytestream, so there are four alarm bits in total. The first slot of a bytestream is a special case. If it is expected to be concatenated but arrives as normal, it is trying to join the bytestream before it. Its mismatch is therefore charged to that previous bytestream, and the previous bytestream of A is D.

A global mode bit sets how alarms are cleared: either by reading them or by writing ones. A per-bytestream mask removes alarm bits from the interrupt level.

Top module: `concat_mismatch_chk`

## Requirements
- R1: After reset, every register reads as zero and irq is low. The mode is clear-on-read and nothing is masked.
- R2: Software can write and read back the expected state and compare-enable registers, one 12-bit word per bytestream. Expected words are at addresses 0..3 and enable words at 4..7, for A..D. Bit k of a word is slot k, where slot 0 is the first slot, and an expected bit of 1 means concatenated. Read data appears on reg_rdata one cycle after reg_rd and holds until the next read.
- R3: On a cycle with rx_valid, rx_map is latched. Bits 12*b+k hold slot k of bytestream b, with A=0. The latched map reads back at addresses 8..11 and does not change while rx_valid is low.
- R4: On a strobe, each enabled slot whose received bit differs from its expected bit sets the alarm bit of its own bytestream. The alarm status is at address 12, with bit b for bytestream b. It is updated one cycle after the strobe.
- R5: A slot whose enable bit is clear never raises an alarm, and no alarm is raised on a cycle without rx_valid.
- R6: If slot 0 of a bytestream is expected concatenated and received normal, the alarm is set for the previous bytestream. B, C and D charge A, B and C, and A charges D. A slot-0 mismatch in the other direction is charged to its own bytestream.
- R7: Alarm bits are sticky. Later matching strobes do not clear them.
- R8: When bit 0 of the mode register (address 14) is 0, a read of address 12 returns the alarm bits and then clears them all. Writes to address 12 have no effect in this mode.
- R9: When mode bit 0 is 1, writing to address 12 clears the alarm bits whose data bit is 1 and leaves the others. Reads do not clear in this mode.
- R10: If an alarm bit is cleared and newly set in the same cycle, it ends up set.
- R11: irq is high exactly when some alarm bit is set and its mask bit is 0. The mask is at address 13, with bit b for bytestream b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data, valid one cycle after reg_rd |
| rx_valid | input | 1 | One-cycle strobe qualifying rx_map |
| rx_map | input | 48 | Received concatenation state per slot |
| irq | output | 1 | Interrupt level |

## Verification
The alarm bits and irq change at the clock edge that samples a strobe or a clearing access, so they are due one cycle later. Register read data is due one cycle after reg_rd. The bench drives every stimulus on a falling edge and samples at the next falling edge, which is exactly one rising edge later. It reads alarm status only through the register port. Because a read clears the alarms in clear-on-read mode, each status read in the vector loop also serves as the clear before the next vector.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
   typedef enum logic {
      CLR_ON_READ  = 1'b0,
      CLR_ON_WRITE = 1'b1
   } clr_mode_e;
endpackage

// File: rtl/cmm_stream_cmp.sv
// Per-bytestream comparator: returns a hit for its own bin and a spill hit
// destined for the bin of the preceding bytestream.
module cmm_stream_cmp #(
   parameter int SLOTS = 12
) (
   input  logic             valid,
   input  logic [SLOTS-1:0] exp_map,
   input  logic [SLOTS-1:0] cmp_en,
   input  logic [SLOTS-1:0] rcv_map,
   output logic             hit_own,
   output logic             hit_prev
);
   logic [SLOTS-1:0] diff;

   assign diff = cmp_en & (exp_map ^ rcv_map);

   // First slot expected concatenated but seen normal: it leans on the
   // neighbour, so the neighbour's bin takes the blame.
   assign hit_prev = valid & diff[0] & exp_map[0];

   generate
      if (SLOTS > 1) begin : g_multi
         assign hit_own = valid & ((diff[0] & ~exp_map[0]) | (|diff[SLOTS-1:1]));
      end else begin : g_single
         assign hit_own = valid & diff[0] & ~exp_map[0];
      end
   endgenerate
endmodule

// File: rtl/cmm_alarm_bin.sv
// Sticky per-bytestream alarm bits; a set in the same cycle beats a clear.
module cmm_alarm_bin #(
   parameter int NBINS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBINS-1:0] set_vec,
   input  logic [NBINS-1:0] clr_vec,
   output logic [NBINS-1:0] status_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/concat_mismatch_chk.sv
module concat_mismatch_chk
   import cmm_pkg::*;
#(
   parameter int NUM_STREAMS = 4,
   parameter int SLOTS       = 12,
   parameter int ADDR_W      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_wr,
   input  logic                         reg_rd,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [SLOTS-1:0]             reg_wdata,
   output logic [SLOTS-1:0]             reg_rdata,
   input  logic                         rx_valid,
   input  logic [NUM_STREAMS*SLOTS-1:0] rx_map,
   output logic                         irq
);
   localparam int TOTAL     = NUM_STREAMS * SLOTS;
   localparam int EXP_BASE  = 0;
   localparam int EN_BASE   = NUM_STREAMS;
   localparam int RCV_BASE  = 2 * NUM_STREAMS;
   localparam int STAT_ADDR = 3 * NUM_STREAMS;
   localparam int MASK_ADDR = STAT_ADDR + 1;
   localparam int MODE_ADDR = STAT_ADDR + 2;

   generate
      if (NUM_STREAMS < 2) begin : g_bad_streams
         $error("NUM_STREAMS must be at least 2");
      end
      if (NUM_STREAMS > SLOTS) begin : g_bad_width
         $error("alarm and mask bits must fit in one data word");
      end
      if ((1 << ADDR_W) <= MODE_ADDR) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_STREAMS-1:0][SLOTS-1:0] exp_q, en_q, rcv_q;
   logic [NUM_STREAMS-1:0]            mask_q, status_q, clr_vec, hit_vec;
   logic [NUM_STREAMS-1:0]            own_hit, spill_hit;
   logic [SLOTS-1:0]                  rd_mux;
   clr_mode_e                         mode_q;
   logic                              stat_sel;

   assign stat_sel = (int'(reg_addr) == STAT_ADDR);

   // Software-owned control registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_q  <= '0;
         en_q   <= '0;
         mask_q <= '0;
         mode_q <= CLR_ON_READ;
      end else if (reg_wr) begin
         for (int s = 0; s < NUM_STREAMS; s++) begin
            if (int'(reg_addr) == EXP_BASE + s) exp_q[s] <= reg_wdata;
            if (int'(reg_addr) == EN_BASE + s)  en_q[s]  <= reg_wdata;
         end
         if (int'(reg_addr) == MASK_ADDR) mask_q <= reg_wdata[NUM_STREAMS-1:0];
         if (int'(reg_addr) == MODE_ADDR) mode_q <= clr_mode_e'(reg_wdata[0]);
      end
   end

   // Snapshot of the received map
   always_ff @(posedge clk) begin
      if (!rst_n)        rcv_q <= '0;
      else if (rx_valid) rcv_q <= rx_map;
   end

   always_comb begin
      rd_mux = '0;
      for (int s = 0; s < NUM_STREAMS; s++) begin
         if (int'(reg_addr) == EXP_BASE + s) rd_mux = exp_q[s];
         if (int'(reg_addr) == EN_BASE + s)  rd_mux = en_q[s];
         if (int'(reg_addr) == RCV_BASE + s) rd_mux = rcv_q[s];
      end
      if (stat_sel)                    rd_mux[NUM_STREAMS-1:0] = status_q;
      if (int'(reg_addr) == MASK_ADDR) rd_mux[NUM_STREAMS-1:0] = mask_q;
      if (int'(reg_addr) == MODE_ADDR) rd_mux[0] = mode_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   // Clear source depends on the selected mode
   always_comb begin
      clr_vec = '0;
      if (mode_q == CLR_ON_WRITE) begin
         if (reg_wr && stat_sel) clr_vec = reg_wdata[NUM_STREAMS-1:0];
      end else if (reg_rd && stat_sel) begin
         clr_vec = '1;
      end
   end

   generate
      for (genvar b = 0; b < NUM_STREAMS; b++) begin : g_stream
         cmm_stream_cmp #(.SLOTS(SLOTS)) u_cmp (
            .valid    (rx_valid),
            .exp_map  (exp_q[b]),
            .cmp_en   (en_q[b]),
            .rcv_map  (rx_map[b*SLOTS +: SLOTS]),
            .hit_own  (own_hit[b]),
            .hit_prev (spill_hit[b])
         );
         assign hit_vec[b] = own_hit[b] | spill_hit[(b + 1) % NUM_STREAMS];
      end
   endgenerate

   cmm_alarm_bin #(.NBINS(NUM_STREAMS)) u_bin (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (hit_vec),
      .clr_vec  (clr_vec),
      .status_q (status_q)
   );

   assign irq = |(status_q & ~mask_q);

   logic [TOTAL-1:0] rcv_flat;
   assign rcv_flat = rcv_q;
endmodule

// File: rtl/cmm_chk.sv
module cmm_chk #(
   parameter int NS    = 4,
   parameter int DW    = 12,
   parameter int TOTAL = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic             rx_valid,
   input logic             irq,
   input logic [NS-1:0]    status_q,
   input logic [NS-1:0]    mask_q,
   input logic [NS-1:0]    hit_vec,
   input logic [TOTAL-1:0] rcv_q,
   input logic [DW-1:0]    reg_rdata
);
   assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   assert_rcv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(rcv_q));

   assert_no_hit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> (hit_vec == '0));

   assert_no_new_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> ((status_q & ~$past(status_q)) == '0));

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr || reg_rd) |=> ((status_q & $past(status_q)) == $past(status_q)));

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec != '0) |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

   assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq);

   assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status_q != '0));
endmodule

bind concat_mismatch_chk cmm_chk #(.NS(NUM_STREAMS), .DW(SLOTS), .TOTAL(TOTAL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .rx_valid  (rx_valid),
   .irq       (irq),
   .status_q  (status_q),
   .mask_q    (mask_q),
   .hit_vec   (hit_vec),
   .rcv_q     (rcv_flat),
   .reg_rdata (reg_rdata)
);

// File: tb/concat_mismatch_chk_tb.sv
module concat_mismatch_chk_tb;
   localparam int CLK_PERIOD = 10;
   localparam int A_EXP = 0, A_EN = 4, A_RCV = 8, A_STAT = 12, A_MASK = 13, A_MODE = 14;
   localparam int NV = 8;

   // {expected[48], enable[48], received[48], alarm[4]}, words ordered {D,C,B,A}
   localparam logic [147:0] VEC [NV] = '{
      {{12'h000,12'h000,12'h000,12'h000},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},{12'h000,12'h000,12'h000,12'h000},4'b0000},
      {{12'h000,12'h000,12'h000,12'h000},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},{12'h000,12'h000,12'h020,12'h000},4'b0010},
      {{12'h000,12'h000,12'h000,12'h000},{12'h000,12'h000,12'h000,12'h000},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},4'b0000},
      {{12'h000,12'h000,12'h000,12'h001},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},{12'h000,12'h000,12'h000,12'h000},4'b1000},
      {{12'h000,12'h001,12'h000,12'h000},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},{12'h000,12'h000,12'h000,12'h000},4'b0010},
      {{12'h000,12'h000,12'h000,12'h000},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},{12'h000,12'h001,12'h000,12'h000},4'b0100},
      {{12'h000,12'h000,12'h009,12'h000},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},{12'h000,12'h000,12'h008,12'h000},4'b0001},
      {{12'h800,12'h000,12'h000,12'h000},{12'hFFF,12'hFFF,12'hFFF,12'hFFF},{12'h000,12'h000,12'h000,12'h000},4'b1000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, rx_valid = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [11:0] reg_wdata = '0;
   logic [11:0] reg_rdata;
   logic [47:0] rx_map = '0;
   logic        irq;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;
   logic [11:0] d;

   concat_mismatch_chk u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_map(rx_map), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [11:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [11:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 4'(a);
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic strobe(input logic [47:0] m);
      @(negedge clk);
      rx_valid = 1'b1; rx_map = m;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic fill(input int base, input logic [11:0] v);
      for (int s = 0; s < 4; s++) wr(base + s, v);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog all-requirements actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 irq", {11'd0, irq}, 12'h000);
      rd(A_STAT, d); check("R1 status", d, 12'h000);
      rd(A_MASK, d); check("R1 mask", d, 12'h000);
      rd(A_MODE, d); check("R1 mode", d, 12'h000);
      rd(A_EXP+1, d); check("R1 expected", d, 12'h000);
      rd(A_EN+2, d); check("R1 enable", d, 12'h000);
      rd(A_RCV+3, d); check("R1 received", d, 12'h000);

      // R4 R5 R6: vector table, clear-on-read clears between entries
      for (int i = 0; i < NV; i++) begin
         logic [47:0] ve, vn, vr;
         logic [3:0]  vs;
         {ve, vn, vr, vs} = VEC[i];
         for (int s = 0; s < 4; s++) begin
            wr(A_EXP + s, ve[s*12 +: 12]);
            wr(A_EN + s, vn[s*12 +: 12]);
         end
         strobe(vr);
         check($sformatf("R4/R5/R6 irq vec%0d", i), {11'd0, irq}, {11'd0, |vs});
         rd(A_STAT, d);
         check($sformatf("R4/R5/R6 alarm vec%0d", i), d, {8'd0, vs});
      end

      // R2: readback
      wr(A_EXP+2, 12'hABC); rd(A_EXP+2, d); check("R2 expected readback", d, 12'hABC);
      wr(A_EN+3, 12'h5A5);  rd(A_EN+3, d);  check("R2 enable readback", d, 12'h5A5);
      rd(A_EXP+2, d);
      repeat (3) @(negedge clk);
      check("R2 rdata holds", reg_rdata, 12'hABC);

      // R3: received map capture and hold
      fill(A_EN, 12'h000);
      fill(A_EXP, 12'h000);
      strobe({12'h111, 12'h222, 12'h333, 12'h444});
      rd(A_RCV+1, d); check("R3 received B", d, 12'h333);
      rd(A_RCV+3, d); check("R3 received D", d, 12'h111);
      @(negedge clk); rx_map = '1;
      repeat (3) @(negedge clk);
      rd(A_RCV+1, d); check("R3 no strobe hold", d, 12'h333);
      rd(A_STAT, d); check("R5 disabled slots", d, 12'h000);

      // R7 / R8: sticky and clear-on-read
      fill(A_EN, 12'hFFF);
      strobe({12'h000, 12'h080, 12'h000, 12'h000});
      strobe(48'h0);
      strobe(48'h0);
      rd(A_STAT, d); check("R7 sticky", d, 12'h004);
      rd(A_STAT, d); check("R8 cleared by read", d, 12'h000);
      strobe({12'h002, 12'h000, 12'h000, 12'h000});
      wr(A_STAT, 12'h00F);
      check("R8 write ignored irq", {11'd0, irq}, 12'h001);
      rd(A_STAT, d); check("R8 write ignored", d, 12'h008);

      // R9: clear-on-write
      wr(A_MODE, 12'h001);
      rd(A_MODE, d); check("R9 mode readback", d, 12'h001);
      strobe({12'h000, 12'h000, 12'h004, 12'h001});
      rd(A_STAT, d); check("R9 set", d, 12'h003);
      rd(A_STAT, d); check("R9 read no clear", d, 12'h003);
      wr(A_STAT, 12'h000);
      rd(A_STAT, d); check("R9 write zero keeps", d, 12'h003);
      wr(A_STAT, 12'h001);
      rd(A_STAT, d); check("R9 write one clears", d, 12'h002);

      // R10: set beats clear in the same cycle
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(A_STAT); reg_wdata = 12'h003;
      rx_valid = 1'b1; rx_map = {12'h000, 12'h000, 12'h000, 12'h010};
      @(negedge clk);
      reg_wr = 1'b0; rx_valid = 1'b0;
      rd(A_STAT, d); check("R10 set wins", d, 12'h001);

      // R11: interrupt masking
      check("R11 irq unmasked", {11'd0, irq}, 12'h001);
      wr(A_MASK, 12'h001);
      check("R11 irq masked", {11'd0, irq}, 12'h000);
      wr(A_MASK, 12'h00E);
      check("R11 other masks", {11'd0, irq}, 12'h001);
      rd(A_MASK, d); check("R11 mask readback", d, 12'h00E);
      wr(A_STAT, 12'h001);
      check("R11 irq after clear", {11'd0, irq}, 12'h000);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule